// File: doc/BRIEF.md
# Load-Store Effective Address Generator

This block turns the operands of a single load or store into the memory address to access and the updated base value. The base value can be written back before the access or after it. A decode stage provides the base register value and its index, the index of the data register, the address of the instruction, and either a signed immediate offset or a register offset. The register offset arrives already shifted by an external shifter. The decode stage also supplies an add or subtract choice, an indexing mode, the access size and a load/store flag. The block registers its results one cycle after an input strobe.

When the base index names the program counter, the block uses a value derived from the instruction address in place of the base value. The block also checks whether the operand combination is allowed. Any disallowed combination raises an illegal flag, and the flag suppresses writeback. The shift type and amount that were applied to a register offset are presented only so that their legality can be checked. The block never applies them.

Top module: `lsag_top`

## Requirements
- R1: With indexing mode 0 (offset), the effective address is base plus the offset, or base minus the offset when `subtract` is 1. Writeback enable is 0.
- R2: With indexing mode 1 (pre-indexed), the effective address and the writeback value both equal base ± offset. Writeback enable is 1 when the operation is legal.
- R3: With indexing mode 2 (post-indexed), the effective address is the unmodified base and the writeback value is base ± offset. Writeback enable is 1 when the operation is legal.
- R4: When the base index is 15, the base used is the instruction address plus 4 with bits [1:0] then cleared, and the base value input is ignored.
- R5: A base index of 15 together with a store (`isLoad`=0), or together with mode 1 or 2, raises the illegal flag.
- R6: With `useImm`=1, an immediate below −255 or above +4095 raises the illegal flag. Both limits themselves are legal.
- R7: In mode 1 or 2, equal base and data indices raise the illegal flag. In mode 0 they are allowed.
- R8: Access sizes are 0 byte, 1 halfword, 2 word and 3 doubleword. Shift kinds are 0 none, 1 LSL, 2 LSR, 3 ASR, 4 ROR and 5 RRX. With a register offset, the following raise the illegal flag:
  - a byte or halfword access with any kind other than none, or LSL with an amount above 3;
  - a doubleword access with any kind other than none;
  - a word access with kind 6 or 7.
  The shift fields are ignored when `useImm`=1.
- R9: Mode code 3 raises the illegal flag. Whenever the illegal flag is 1, writeback enable is 0.
- R10: Address arithmetic wraps modulo 2^32 and has no overflow indication.
- R11: Results appear, with `outValid`=1, on the clock edge after an edge at which `inValid`=1. `outValid` is 0 after reset and 0 after an edge without `inValid`. When no new input arrives, the result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input operands are valid this cycle |
| baseVal | input | 32 | Value of the base register |
| baseIdx | input | 4 | Index of the base register (15 = program counter) |
| dataIdx | input | 4 | Index of the register loaded or stored |
| instrAddr | input | 32 | Address of the instruction |
| useImm | input | 1 | 1 = immediate offset, 0 = register offset |
| immOffset | input | 14 | Signed immediate offset |
| regOffset | input | 32 | Register offset, already shifted |
| shiftKind | input | 3 | Shift kind applied to the register offset |
| shiftAmt | input | 5 | Shift amount applied to the register offset |
| subtract | input | 1 | 1 = subtract the offset from the base |
| idxMode | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed |
| accSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| isLoad | input | 1 | 1 = load, 0 = store |
| outValid | output | 1 | Results are valid |
| effAddr | output | 32 | Effective address |
| wbData | output | 32 | Updated base value |
| wbEn | output | 1 | Base writeback enable |
| illegal | output | 1 | Disallowed operand combination |

## Verification
The bench probes both ends of the immediate range: −255 and +4095 must be accepted, and −256 and +4096 must be flagged. A comparison with the wrong sign or an off-by-one error would misclassify at least one of the four. A program-counter base is driven with an instruction address that is not word-aligned. A design that skips the +4 step or the alignment step returns a visibly shifted address. A design that never ignores the base value input also returns a wrong address, because the bench drives a nonzero value on that input. Post-indexed operations are checked for an address equal to the unmodified base; a design that swaps the address and writeback paths fails this check. The bench also checks the following:
- base/data aliasing in each indexing mode;
- shift legality at the LSL amount limit of 3;
- a wrapped sum;
- outputs that hold during idle cycles. A design that drops the load enable on its output registers fails this check.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

  typedef enum logic [1:0] {
    IDX_OFFSET = 2'd0,
    IDX_PRE    = 2'd1,
    IDX_POST   = 2'd2,
    IDX_BAD    = 2'd3
  } idxMode_e;

  typedef enum logic [1:0] {
    SZ_BYTE   = 2'd0,
    SZ_HALF   = 2'd1,
    SZ_WORD   = 2'd2,
    SZ_DOUBLE = 2'd3
  } accSize_e;

  typedef enum logic [2:0] {
    SH_NONE = 3'd0,
    SH_LSL  = 3'd1,
    SH_LSR  = 3'd2,
    SH_ASR  = 3'd3,
    SH_ROR  = 3'd4,
    SH_RRX  = 3'd5
  } shiftKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic pcBase;
    logic useImm;
    logic addrIsBase;
    logic wbEn;
    logic illegal;
  } eaCtrl_t;

endpackage

// File: rtl/lsag_ctrl.sv
module lsag_ctrl
  import lsag_pkg::*;
#(
  parameter int IDX_W       = 4,
  parameter int IMM_W       = 14,
  parameter int SHAMT_W     = 5,
  parameter int PC_IDX      = 15,
  parameter int MIN_IMM     = -255,
  parameter int MAX_IMM     = 4095,
  parameter int MAX_NARROW  = 3
) (
  input  logic                    useImm,
  input  logic signed [IMM_W-1:0] immOffset,
  input  logic [2:0]              shiftKind,
  input  logic [SHAMT_W-1:0]      shiftAmt,
  input  logic [IDX_W-1:0]        baseIdx,
  input  logic [IDX_W-1:0]        dataIdx,
  input  logic [1:0]              idxMode,
  input  logic [1:0]              accSize,
  input  logic                    isLoad,
  output eaCtrl_t                 ctrl
);

  localparam logic [IDX_W-1:0]   PC_CODE    = IDX_W'(PC_IDX);
  localparam logic [SHAMT_W-1:0] NARROW_LIM = SHAMT_W'(MAX_NARROW);

  logic isPc, indexing, immBad, modeBad, pcBad, aliasBad, shiftBad;
  logic kindNone;

  always_comb begin
    isPc     = (baseIdx == PC_CODE);
    indexing = (idxMode == IDX_PRE) || (idxMode == IDX_POST);
    modeBad  = (idxMode == IDX_BAD);
    immBad   = useImm && ((int'(immOffset) < MIN_IMM) || (int'(immOffset) > MAX_IMM));
    pcBad    = isPc && (!isLoad || indexing);
    aliasBad = indexing && (baseIdx == dataIdx);
    kindNone = (shiftKind == SH_NONE);
    shiftBad = 1'b0;
    if (!useImm) begin
      unique case (accSize)
        SZ_BYTE, SZ_HALF:
          shiftBad = !(kindNone || (shiftKind == SH_LSL && shiftAmt <= NARROW_LIM));
        SZ_DOUBLE:
          shiftBad = !kindNone;
        default:
          shiftBad = (shiftKind > SH_RRX);
      endcase
    end
    ctrl.pcBase     = isPc;
    ctrl.useImm     = useImm;
    ctrl.addrIsBase = (idxMode == IDX_POST);
    ctrl.illegal    = immBad | modeBad | pcBad | aliasBad | shiftBad;
    ctrl.wbEn       = indexing && !ctrl.illegal;
  end

  // R5: a program-counter base on a store can never be legal
  always_comb begin
    if (isPc && !isLoad) a_r5_pc_store: assert (ctrl.illegal);
  end

endmodule

// File: rtl/lsag_datapath.sv
module lsag_datapath
  import lsag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IMM_W    = 14,
  parameter int PC_AHEAD = 4,
  parameter int ALIGN_B  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  eaCtrl_t                 ctrl,
  input  logic [1:0]              idxMode,
  input  logic [ADDR_W-1:0]       baseVal,
  input  logic [ADDR_W-1:0]       instrAddr,
  input  logic signed [IMM_W-1:0] immOffset,
  input  logic [ADDR_W-1:0]       regOffset,
  input  logic                    subtract,
  output logic                    outValid,
  output logic [ADDR_W-1:0]       effAddr,
  output logic [ADDR_W-1:0]       wbData,
  output logic                    wbEn,
  output logic                    illegal
);

  localparam logic [ADDR_W-1:0] AHEAD = ADDR_W'(PC_AHEAD);

  logic [ADDR_W-1:0] pcRaw, pcVal, baseEff, offExt, sum, addrNext;

  always_comb begin
    pcRaw = instrAddr + AHEAD;
  end

  // clear the low alignment bits of the program-counter value
  genvar gi;
  generate
    for (gi = 0; gi < ADDR_W; gi++) begin : g_align
      if (gi < ALIGN_B) begin : g_lo
        assign pcVal[gi] = 1'b0;
      end else begin : g_hi
        assign pcVal[gi] = pcRaw[gi];
      end
    end
  endgenerate

  always_comb begin
    baseEff  = ctrl.pcBase ? pcVal : baseVal;
    offExt   = ctrl.useImm ? {{(ADDR_W-IMM_W){immOffset[IMM_W-1]}}, immOffset} : regOffset;
    sum      = subtract ? (baseEff - offExt) : (baseEff + offExt);
    addrNext = ctrl.addrIsBase ? baseEff : sum;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      effAddr  <= '0;
      wbData   <= '0;
      wbEn     <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        effAddr <= addrNext;
        wbData  <= sum;
        wbEn    <= ctrl.wbEn;
        illegal <= ctrl.illegal;
      end
    end
  end

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(effAddr) && $stable(wbData));
  a_r1_offset_no_wb: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && idxMode == IDX_OFFSET) |=> !wbEn);
  a_r2_pre_same: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && idxMode == IDX_PRE) |=> (effAddr == wbData));
  a_r3_post_base: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && idxMode == IDX_POST && !ctrl.pcBase) |=> (effAddr == $past(baseVal)));
  a_r9_wb_needs_legal: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !(wbEn && illegal));

endmodule

// File: rtl/lsag_top.sv
module lsag_top
  import lsag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 4,
  parameter int IMM_W      = 14,
  parameter int SHAMT_W    = 5,
  parameter int PC_IDX     = 15,
  parameter int PC_AHEAD   = 4,
  parameter int ALIGN_B    = 2,
  parameter int MIN_IMM    = -255,
  parameter int MAX_IMM    = 4095,
  parameter int MAX_NARROW = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [ADDR_W-1:0]       baseVal,
  input  logic [IDX_W-1:0]        baseIdx,
  input  logic [IDX_W-1:0]        dataIdx,
  input  logic [ADDR_W-1:0]       instrAddr,
  input  logic                    useImm,
  input  logic signed [IMM_W-1:0] immOffset,
  input  logic [ADDR_W-1:0]       regOffset,
  input  logic [2:0]              shiftKind,
  input  logic [SHAMT_W-1:0]      shiftAmt,
  input  logic                    subtract,
  input  logic [1:0]              idxMode,
  input  logic [1:0]              accSize,
  input  logic                    isLoad,
  output logic                    outValid,
  output logic [ADDR_W-1:0]       effAddr,
  output logic [ADDR_W-1:0]       wbData,
  output logic                    wbEn,
  output logic                    illegal
);

  eaCtrl_t ctrl;

  lsag_ctrl #(
    .IDX_W(IDX_W), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W), .PC_IDX(PC_IDX),
    .MIN_IMM(MIN_IMM), .MAX_IMM(MAX_IMM), .MAX_NARROW(MAX_NARROW)
  ) u_ctrl (
    .useImm(useImm), .immOffset(immOffset), .shiftKind(shiftKind),
    .shiftAmt(shiftAmt), .baseIdx(baseIdx), .dataIdx(dataIdx),
    .idxMode(idxMode), .accSize(accSize), .isLoad(isLoad), .ctrl(ctrl)
  );

  lsag_datapath #(
    .ADDR_W(ADDR_W), .IMM_W(IMM_W), .PC_AHEAD(PC_AHEAD), .ALIGN_B(ALIGN_B)
  ) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ctrl(ctrl), .idxMode(idxMode),
    .baseVal(baseVal), .instrAddr(instrAddr), .immOffset(immOffset),
    .regOffset(regOffset), .subtract(subtract), .outValid(outValid),
    .effAddr(effAddr), .wbData(wbData), .wbEn(wbEn), .illegal(illegal)
  );

endmodule

// File: tb/sim_lsag_top.sv
module sim_lsag_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [31:0] baseVal;
  logic [3:0]  baseIdx, dataIdx;
  logic [31:0] instrAddr;
  logic        useImm;
  logic signed [13:0] immOffset;
  logic [31:0] regOffset;
  logic [2:0]  shiftKind;
  logic [4:0]  shiftAmt;
  logic        subtract;
  logic [1:0]  idxMode, accSize;
  logic        isLoad;
  logic        outValid;
  logic [31:0] effAddr, wbData;
  logic        wbEn, illegal;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  lsag_top u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .baseVal(baseVal),
    .baseIdx(baseIdx), .dataIdx(dataIdx), .instrAddr(instrAddr),
    .useImm(useImm), .immOffset(immOffset), .regOffset(regOffset),
    .shiftKind(shiftKind), .shiftAmt(shiftAmt), .subtract(subtract),
    .idxMode(idxMode), .accSize(accSize), .isLoad(isLoad),
    .outValid(outValid), .effAddr(effAddr), .wbData(wbData),
    .wbEn(wbEn), .illegal(illegal)
  );

  typedef struct {
    logic [31:0] addr;
    logic [31:0] wb;
    logic        we;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t sb[$];

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: computes expectation from the requirements and applies stimulus
  task automatic drive(input string tag, input logic [31:0] bv, input logic [3:0] bi,
                       input logic [3:0] di, input logic [31:0] ia, input logic ui,
                       input int imm, input logic [31:0] ro, input logic [2:0] sk,
                       input logic [4:0] sa, input logic sub, input logic [1:0] md,
                       input logic [1:0] sz, input logic ld);
    exp_t e;
    logic [31:0] b, o, s;
    logic indexed, ill;
    b = (bi == 4'd15) ? ((ia + 32'd4) & 32'hFFFF_FFFC) : bv;
    o = ui ? 32'(imm) : ro;
    s = sub ? b - o : b + o;
    indexed = (md == 2'd1) || (md == 2'd2);
    ill = (md == 2'd3);
    if (bi == 4'd15 && (!ld || indexed)) ill = 1'b1;
    if (ui && (imm < -255 || imm > 4095)) ill = 1'b1;
    if (indexed && bi == di) ill = 1'b1;
    if (!ui) begin
      if (sz <= 2'd1 && !(sk == 3'd0 || (sk == 3'd1 && sa <= 5'd3))) ill = 1'b1;
      if (sz == 2'd3 && sk != 3'd0) ill = 1'b1;
      if (sz == 2'd2 && sk > 3'd5) ill = 1'b1;
    end
    e.addr = (md == 2'd2) ? b : s;
    e.wb   = s;
    e.we   = indexed && !ill;
    e.ill  = ill;
    e.tag  = tag;
    @(negedge clk);
    sb.push_back(e);
    inValid = 1'b1; baseVal = bv; baseIdx = bi; dataIdx = di; instrAddr = ia;
    useImm = ui; immOffset = 14'(imm); regOffset = ro; shiftKind = sk;
    shiftAmt = sa; subtract = sub; idxMode = md; accSize = sz; isLoad = ld;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
    baseVal = 32'hDEAD_BEEF;
  endtask

  // Monitor: pops and compares as results appear
  always @(negedge clk) begin
    if (rstN === 1'b1 && outValid === 1'b1) begin
      if (sb.size() == 0) begin
        total++; bad++;
        $display("FAIL R11 unexpected outValid actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "effAddr", effAddr, e.addr);
        check(e.tag, "wbData", wbData, e.wb);
        check(e.tag, "wbEn", {31'd0, wbEn}, {31'd0, e.we});
        check(e.tag, "illegal", {31'd0, illegal}, {31'd0, e.ill});
      end
    end
  end

  initial begin
    #(4 * 20000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    rstN = 1'b0; inValid = 1'b0; baseVal = '0; baseIdx = '0; dataIdx = '0;
    instrAddr = '0; useImm = 1'b0; immOffset = '0; regOffset = '0;
    shiftKind = '0; shiftAmt = '0; subtract = 1'b0; idxMode = '0;
    accSize = '0; isLoad = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", "reset outValid", {31'd0, outValid}, 32'd0);

    //      tag   base          bi  di  instr        ui imm    regOff       sk sa sub md sz ld
    drive("R1",  32'h0000_1000, 1,  2,  32'h0,       1, 8,     0,           0, 0, 0, 0, 2, 1);
    drive("R1",  32'h0000_1000, 1,  2,  32'h0,       0, 0,     32'h40,      1, 2, 1, 0, 2, 1);
    drive("R2",  32'h0000_2000, 3,  4,  32'h0,       1, 4,     0,           0, 0, 0, 1, 2, 1);
    drive("R3",  32'h0000_3000, 5,  6,  32'h0,       0, 0,     32'h100,     1, 2, 0, 2, 2, 0);
    drive("R4",  32'h1234_5678, 15, 0,  32'h0000_2002, 1, 16,  0,           0, 0, 0, 0, 2, 1);
    drive("R4",  32'h1234_5678, 15, 0,  32'h0000_2007, 1, 4,   0,           0, 0, 1, 0, 2, 1);
    drive("R5",  32'h0,         15, 0,  32'h0000_1000, 1, 0,   0,           0, 0, 0, 0, 2, 0);
    drive("R5",  32'h0,         15, 0,  32'h0000_1000, 1, 4,   0,           0, 0, 0, 1, 2, 1);
    drive("R6",  32'h0000_1000, 1,  2,  32'h0,       1, -255,  0,           0, 0, 0, 0, 2, 1);
    drive("R6",  32'h0000_1000, 1,  2,  32'h0,       1, -256,  0,           0, 0, 0, 0, 2, 1);
    drive("R6",  32'h0000_1000, 1,  2,  32'h0,       1, 4095,  0,           0, 0, 0, 1, 2, 1);
    drive("R6",  32'h0000_1000, 1,  2,  32'h0,       1, 4096,  0,           0, 0, 0, 1, 2, 1);
    drive("R7",  32'h0000_4000, 7,  7,  32'h0,       1, 4,     0,           0, 0, 0, 1, 2, 1);
    drive("R7",  32'h0000_4000, 7,  7,  32'h0,       1, 4,     0,           0, 0, 0, 2, 2, 1);
    drive("R7",  32'h0000_4000, 7,  7,  32'h0,       1, 4,     0,           0, 0, 0, 0, 2, 1);
    drive("R8",  32'h0000_5000, 1,  2,  32'h0,       0, 0,     32'h8,       1, 3, 0, 0, 0, 1);
    drive("R8",  32'h0000_5000, 1,  2,  32'h0,       0, 0,     32'h8,       1, 4, 0, 0, 0, 1);
    drive("R8",  32'h0000_5000, 1,  2,  32'h0,       0, 0,     32'h8,       3, 1, 0, 0, 1, 1);
    drive("R8",  32'h0000_5000, 1,  2,  32'h0,       0, 0,     32'h8,       1, 1, 0, 0, 3, 1);
    drive("R8",  32'h0000_5000, 1,  2,  32'h0,       0, 0,     32'h8,       4, 7, 0, 0, 2, 1);
    drive("R8",  32'h0000_5000, 1,  2,  32'h0,       0, 0,     32'h8,       6, 1, 0, 0, 2, 1);
    drive("R8",  32'h0000_5000, 1,  2,  32'h0,       1, 12,    0,           3, 9, 0, 0, 3, 1);
    drive("R9",  32'h0000_6000, 1,  2,  32'h0,       1, 4,     0,           0, 0, 0, 3, 2, 1);
    drive("R10", 32'hFFFF_FFF0, 1,  2,  32'h0,       1, 32,    0,           0, 0, 0, 1, 2, 1);
    drive("R10", 32'h0000_0010, 1,  2,  32'h0,       0, 0,     32'h20,      0, 0, 1, 2, 2, 1);
    idle();
    repeat (2) @(negedge clk);
    held = effAddr;
    check("R11", "idle outValid", {31'd0, outValid}, 32'd0);
    repeat (3) @(negedge clk);
    check("R11", "held effAddr", effAddr, held);
    check("R11", "held value", effAddr, 32'h0000_0010);
    check("R11", "scoreboard drained", sb.size(), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule